// File: doc/BRIEF.md
# Sector Erase Scheduler with Suspend

This block sequences the erase of a flash array split into equal sectors. A sector-erase command opens a timed acceptance window. Every further sector-erase command inside that window adds its sector to the selection and restarts the full window. When the window runs out, the scheduler walks the selected sectors from the lowest index to the highest. It hands each sector to a per-sector erase engine twice: first to preprogram the sector to all zeros, then to erase it to all ones. A chip-erase command selects every sector at once and starts without a window.

The host can suspend a sector erase, either inside the window or while a sector is being worked on. While suspended, it may program sectors that are not in the selection, and a resume then carries on from the sector that was interrupted. Protected sectors are left out of the work list. A selection made up only of protected sectors still keeps the block busy for a fixed time before it goes back to read mode. All commands arrive as decoded one-cycle pulses. The analog pulse timing is left to the engine.

Top module: `sector_erase_sched`

## Requirements
- R1: After reset the block is in read mode. `sel_mask` is zero, and `win_open`, `busy`, `suspended`, `eng_req`, `eng_abort` and `prog_ok` are all low.
- R2: A sector-erase pulse taken in read mode or inside the window sets bit `cmd_sect` of `sel_mask`. `win_open` is then high for exactly WIN_CYC cycles, counted from the cycle after the most recent such pulse. When it falls, `busy` rises.
- R3: A chip-erase, resume, program or other-command pulse taken inside the window clears `sel_mask`. It closes the window and returns to read mode without starting any engine work.
- R4: Selected sectors are handed to the engine one at a time in ascending index order. For each sector the engine is first asked for preprogram (`eng_phase`=0) and, after `eng_done`, for erase (`eng_phase`=1). `cur_sect` names the sector and is always part of `sel_mask`.
- R5: Sectors whose `prot_mask` bit is set when the work list is built are skipped. The work list is built when the window closes, when suspend ends the window, or when a chip erase is accepted.
- R6: If no selected sector is unprotected, `busy` stays high for exactly PROT_CYC+1 cycles without any engine request. The block then returns to read mode with `sel_mask` cleared.
- R7: A suspend pulse taken inside the window ends the window on the next cycle. `suspended` goes high, `busy` stays low and `sel_mask` is kept.
- R8: A suspend pulse taken during a sector erase raises `eng_abort`. `suspended` rises once the engine pulses `eng_done`, and no later than SUSP_LAT cycles after the pulse. With no acknowledgement it rises after exactly SUSP_LAT cycles.
- R9: Suspend is ignored in read mode and during a chip erase: neither `suspended` nor `eng_abort` rises.
- R10: A program pulse taken in read mode, or while suspended for a sector that is not in `sel_mask`, gives a one-cycle `prog_ok` on the next cycle. While suspended, a program to a selected sector gives none.
- R11: A resume pulse while suspended brings back `busy`. Work restarts from the preprogram phase of the interrupted sector. Further resume pulses are ignored, and a new suspend is accepted after a resume.
- R12: While `busy`, every command other than an accepted suspend is ignored: `sel_mask` keeps its value, no `prog_ok` is given and the erase order is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_serase | input | 1 | Sector-erase command pulse |
| cmd_cerase | input | 1 | Chip-erase command pulse |
| cmd_susp | input | 1 | Erase-suspend command pulse |
| cmd_resume | input | 1 | Erase-resume command pulse |
| cmd_prog | input | 1 | Program command pulse |
| cmd_other | input | 1 | Any other command pulse |
| cmd_sect | input | SW | Sector index carried by sector-erase and program |
| prot_mask | input | N_SECT | One bit per sector, 1 = protected |
| eng_done | input | 1 | Engine finished its phase or acknowledged an abort |
| sel_mask | output | N_SECT | Sectors selected for erase |
| win_open | output | 1 | Acceptance window running |
| busy | output | 1 | Erase work in progress |
| suspended | output | 1 | Erase suspended |
| cur_sect | output | SW | Sector handed to the engine |
| eng_req | output | 1 | Engine request for `cur_sect` |
| eng_phase | output | 1 | 0 = preprogram, 1 = erase |
| eng_abort | output | 1 | Engine asked to stop for suspend |
| prog_ok | output | 1 | Program command accepted |

## Verification
Some properties are checked by the bound checker on every cycle: the window never lasting longer than WIN_CYC cycles after a sector-erase pulse, the three modes being mutually exclusive, the abort drain never outlasting SUSP_LAT, no suspend during a chip erase, the engine always working on a selected sector, and preprogram always coming before erase on that sector. Other behaviours can only be shown by the bench's scenarios, which watch whole sequences: the ascending order, skipped protected sectors, the exact busy time for an all-protected selection, cancellation, and the restart of an interrupted sector after resume.

// File: rtl/sesched_pkg.sv
`timescale 1ns/1ps
package sesched_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WIN   = 3'd1,
    ST_RUN   = 3'd2,
    ST_PRE   = 3'd3,
    ST_ERS   = 3'd4,
    ST_DRAIN = 3'd5,
    ST_SUSP  = 3'd6,
    ST_PWAIT = 3'd7
  } sched_st_t;

  localparam logic PH_PREPROG = 1'b0;
  localparam logic PH_ERASE   = 1'b1;
endpackage

// File: rtl/sesched_downcnt.sv
`timescale 1ns/1ps
module sesched_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sesched_pick.sv
`timescale 1ns/1ps
module sesched_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/sector_erase_sched.sv
`timescale 1ns/1ps
module sector_erase_sched
  import sesched_pkg::*;
#(
  parameter int N_SECT   = 8,
  parameter int WIN_CYC  = 2500,
  parameter int SUSP_LAT = 1000,
  parameter int PROT_CYC = 5000,
  localparam int SW      = $clog2(N_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_serase,
  input  logic              cmd_cerase,
  input  logic              cmd_susp,
  input  logic              cmd_resume,
  input  logic              cmd_prog,
  input  logic              cmd_other,
  input  logic [SW-1:0]     cmd_sect,
  input  logic [N_SECT-1:0] prot_mask,
  input  logic              eng_done,
  output logic [N_SECT-1:0] sel_mask,
  output logic              win_open,
  output logic              busy,
  output logic              suspended,
  output logic [SW-1:0]     cur_sect,
  output logic              eng_req,
  output logic              eng_phase,
  output logic              eng_abort,
  output logic              prog_ok
);
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam int LW = $clog2(SUSP_LAT + 1);
  localparam int PW = $clog2(PROT_CYC + 1);

  function automatic logic [N_SECT-1:0] sect_bit(input logic [SW-1:0] s);
    return {{(N_SECT-1){1'b0}}, 1'b1} << s;
  endfunction

  sched_st_t         st_q, st_d;
  logic [N_SECT-1:0] sel_q, sel_d, todo_q, todo_d;
  logic [SW-1:0]     cur_q, cur_d;
  logic              chip_q, chip_d, did_q, did_d;
  logic              prog_ok_q, prog_ok_d;

  logic win_load, win_dec, win_zero;
  logic lat_load, lat_dec, lat_zero;
  logic pw_load, pw_dec, pw_zero;
  logic          pick_any;
  logic [SW-1:0] pick_idx;

  // named internal events
  logic ev_win_add, ev_cancel, ev_susp_ok, ev_resume_ok, ev_sect_done;

  sesched_downcnt #(.W(WW)) u_win (
    .clk(clk), .rst_n(rst_n), .load(win_load),
    .load_val(WW'(WIN_CYC - 1)), .dec(win_dec), .zero(win_zero)
  );

  sesched_downcnt #(.W(LW)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(lat_load),
    .load_val(LW'(SUSP_LAT - 1)), .dec(lat_dec), .zero(lat_zero)
  );

  sesched_downcnt #(.W(PW)) u_pwait (
    .clk(clk), .rst_n(rst_n), .load(pw_load),
    .load_val(PW'(PROT_CYC - 1)), .dec(pw_dec), .zero(pw_zero)
  );

  sesched_pick #(.N(N_SECT), .IW(SW)) u_pick (
    .req(todo_q), .any(pick_any), .idx(pick_idx)
  );

  assign ev_win_add   = cmd_serase && (st_q == ST_IDLE || st_q == ST_WIN);
  assign ev_cancel    = (st_q == ST_WIN) && !cmd_serase && !cmd_susp &&
                        (cmd_cerase || cmd_resume || cmd_prog || cmd_other);
  assign ev_susp_ok   = cmd_susp && !chip_q &&
                        (st_q == ST_WIN || st_q == ST_RUN || st_q == ST_PRE || st_q == ST_ERS);
  assign ev_resume_ok = cmd_resume && (st_q == ST_SUSP);
  assign ev_sect_done = (st_q == ST_ERS) && eng_done && !ev_susp_ok;

  always_comb begin
    st_d      = st_q;
    sel_d     = sel_q;
    todo_d    = todo_q;
    cur_d     = cur_q;
    chip_d    = chip_q;
    did_d     = did_q;
    prog_ok_d = 1'b0;
    win_load  = 1'b0;
    win_dec   = 1'b0;
    lat_load  = 1'b0;
    lat_dec   = 1'b0;
    pw_load   = 1'b0;
    pw_dec    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ev_win_add) begin
          st_d     = ST_WIN;
          sel_d    = sect_bit(cmd_sect);
          win_load = 1'b1;
        end else if (cmd_cerase) begin
          st_d   = ST_RUN;
          sel_d  = '1;
          todo_d = ~prot_mask;
          chip_d = 1'b1;
        end else if (cmd_prog) begin
          prog_ok_d = 1'b1;
        end
      end
      ST_WIN: begin
        if (ev_win_add) begin
          sel_d    = sel_q | sect_bit(cmd_sect);
          win_load = 1'b1;
        end else if (ev_susp_ok) begin
          st_d   = ST_SUSP;
          todo_d = sel_q & ~prot_mask;
        end else if (ev_cancel) begin
          st_d  = ST_IDLE;
          sel_d = '0;
        end else if (win_zero) begin
          st_d   = ST_RUN;
          todo_d = sel_q & ~prot_mask;
        end else begin
          win_dec = 1'b1;
        end
      end
      ST_RUN: begin
        if (ev_susp_ok) begin
          st_d = ST_SUSP;
        end else if (pick_any) begin
          st_d  = ST_PRE;
          cur_d = pick_idx;
        end else if (did_q) begin
          st_d   = ST_IDLE;
          sel_d  = '0;
          chip_d = 1'b0;
          did_d  = 1'b0;
        end else begin
          st_d    = ST_PWAIT;
          pw_load = 1'b1;
        end
      end
      ST_PRE: begin
        if (ev_susp_ok) begin
          st_d     = ST_DRAIN;
          lat_load = 1'b1;
        end else if (eng_done) begin
          st_d = ST_ERS;
        end
      end
      ST_ERS: begin
        if (ev_susp_ok) begin
          st_d     = ST_DRAIN;
          lat_load = 1'b1;
        end else if (ev_sect_done) begin
          st_d          = ST_RUN;
          todo_d[cur_q] = 1'b0;
          did_d         = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (eng_done || lat_zero) st_d    = ST_SUSP;
        else                      lat_dec = 1'b1;
      end
      ST_SUSP: begin
        if (ev_resume_ok) begin
          st_d = ST_RUN;
        end else if (cmd_prog && !sel_q[cmd_sect]) begin
          prog_ok_d = 1'b1;
        end
      end
      ST_PWAIT: begin
        if (pw_zero) begin
          st_d   = ST_IDLE;
          sel_d  = '0;
          chip_d = 1'b0;
          did_d  = 1'b0;
        end else begin
          pw_dec = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sel_q     <= '0;
      todo_q    <= '0;
      cur_q     <= '0;
      chip_q    <= 1'b0;
      did_q     <= 1'b0;
      prog_ok_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      sel_q     <= sel_d;
      todo_q    <= todo_d;
      cur_q     <= cur_d;
      chip_q    <= chip_d;
      did_q     <= did_d;
      prog_ok_q <= prog_ok_d;
    end
  end

  assign sel_mask  = sel_q;
  assign win_open  = (st_q == ST_WIN);
  assign busy      = (st_q == ST_RUN) || (st_q == ST_PRE) || (st_q == ST_ERS) ||
                     (st_q == ST_DRAIN) || (st_q == ST_PWAIT);
  assign suspended = (st_q == ST_SUSP);
  assign cur_sect  = cur_q;
  assign eng_req   = (st_q == ST_PRE) || (st_q == ST_ERS);
  assign eng_phase = (st_q == ST_ERS) ? PH_ERASE : PH_PREPROG;
  assign eng_abort = (st_q == ST_DRAIN);
  assign prog_ok   = prog_ok_q;
endmodule

// File: rtl/sesched_chk.sv
`timescale 1ns/1ps
module sesched_chk #(
  parameter int N_SECT   = 8,
  parameter int WIN_CYC  = 2500,
  parameter int SUSP_LAT = 1000,
  localparam int SW      = $clog2(N_SECT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_serase,
  input logic [SW-1:0]     cmd_sect,
  input logic [N_SECT-1:0] sel_mask,
  input logic              win_open,
  input logic              busy,
  input logic              suspended,
  input logic [SW-1:0]     cur_sect,
  input logic              eng_req,
  input logic              eng_phase,
  input logic              eng_abort,
  input logic              prog_ok,
  input logic              chip_q
);
  logic [31:0] wcnt, acnt;
  logic        prog_hit, cur_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
      acnt <= '0;
    end else begin
      wcnt <= cmd_serase ? '0 : (win_open ? wcnt + 32'd1 : '0);
      acnt <= eng_abort ? acnt + 32'd1 : '0;
    end
  end

  assign prog_hit = sel_mask[cmd_sect];
  assign cur_hit  = sel_mask[cur_sect];

  // R2
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> wcnt < 32'(WIN_CYC));

  // R7
  modes_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_open, busy, suspended}));

  // R8
  susp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> acnt < 32'(SUSP_LAT));

  // R9
  chip_nosusp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_q |-> (!eng_abort && !suspended));

  // R4
  req_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> cur_hit);

  // R4
  pre_before_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_phase) |-> ($past(eng_req && !eng_phase) && $stable(cur_sect)));

  // R10
  prog_nonsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ok |-> !$past(prog_hit));

  // R12
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy || suspended) && $past(busy || suspended)) |-> $stable(sel_mask));
endmodule

bind sector_erase_sched sesched_chk #(
  .N_SECT(N_SECT), .WIN_CYC(WIN_CYC), .SUSP_LAT(SUSP_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_serase(cmd_serase), .cmd_sect(cmd_sect),
  .sel_mask(sel_mask), .win_open(win_open), .busy(busy), .suspended(suspended),
  .cur_sect(cur_sect), .eng_req(eng_req), .eng_phase(eng_phase),
  .eng_abort(eng_abort), .prog_ok(prog_ok), .chip_q(chip_q)
);

// File: tb/tb_sector_erase_sched.sv
`timescale 1ns/1ps
module tb_sector_erase_sched;
  localparam int N_SECT   = 8;
  localparam int WIN_CYC  = 20;
  localparam int SUSP_LAT = 6;
  localparam int PROT_CYC = 30;
  localparam int ENG_CYC  = 10;

  localparam int C_SER = 0, C_CER = 1, C_SUS = 2, C_RES = 3, C_PRG = 4, C_OTH = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_serase = 0, cmd_cerase = 0, cmd_susp = 0, cmd_resume = 0;
  logic cmd_prog = 0, cmd_other = 0;
  logic [2:0] cmd_sect = '0;
  logic [7:0] prot_mask = '0;
  logic eng_done = 1'b0;
  logic [7:0] sel_mask;
  logic win_open, busy, suspended, eng_req, eng_phase, eng_abort, prog_ok;
  logic [2:0] cur_sect;

  int checks = 0, errors = 0, cycles = 0;
  int ecnt = 0, acnt = 0;
  logic ack_abort = 1'b0;
  logic [2:0] log_s [0:63];
  logic       log_p [0:63];
  int log_n = 0;

  always #2.5 clk = ~clk;

  sector_erase_sched #(
    .N_SECT(N_SECT), .WIN_CYC(WIN_CYC), .SUSP_LAT(SUSP_LAT), .PROT_CYC(PROT_CYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_serase(cmd_serase), .cmd_cerase(cmd_cerase),
    .cmd_susp(cmd_susp), .cmd_resume(cmd_resume), .cmd_prog(cmd_prog),
    .cmd_other(cmd_other), .cmd_sect(cmd_sect), .prot_mask(prot_mask),
    .eng_done(eng_done), .sel_mask(sel_mask), .win_open(win_open), .busy(busy),
    .suspended(suspended), .cur_sect(cur_sect), .eng_req(eng_req),
    .eng_phase(eng_phase), .eng_abort(eng_abort), .prog_ok(prog_ok)
  );

  // erase engine model: finishes a phase after ENG_CYC request cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      eng_done = 1'b0; ecnt = 0; acnt = 0;
    end else begin
      eng_done = 1'b0;
      if (eng_req) begin
        acnt = 0;
        if (ecnt == ENG_CYC - 1) begin
          eng_done = 1'b1; ecnt = 0;
          if (log_n < 64) begin
            log_s[log_n] = cur_sect; log_p[log_n] = eng_phase; log_n++;
          end
        end else ecnt++;
      end else if (eng_abort) begin
        ecnt = 0;
        if (ack_abort && acnt == 2) begin eng_done = 1'b1; acnt = 0; end
        else acnt++;
      end else begin
        ecnt = 0; acnt = 0;
      end
    end
  end

  task automatic summary_exit();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      summary_exit();
    end
  end

  task automatic chk(input string r, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic pulse(input int which, input logic [2:0] s);
    @(negedge clk);
    cmd_sect = s;
    case (which)
      C_SER: cmd_serase = 1'b1;
      C_CER: cmd_cerase = 1'b1;
      C_SUS: cmd_susp   = 1'b1;
      C_RES: cmd_resume = 1'b1;
      C_PRG: cmd_prog   = 1'b1;
      default: cmd_other = 1'b1;
    endcase
    @(negedge clk);
    {cmd_serase, cmd_cerase, cmd_susp, cmd_resume, cmd_prog, cmd_other} = '0;
  endtask

  task automatic wait_idle(input string r);
    int n = 0;
    while ((busy || suspended || win_open) && n < 5000) begin
      @(negedge clk); n++;
    end
    chk(r, "returned to read mode", 32'(n < 5000), 32'd1);
  endtask

  task automatic wait_phase(input logic ph);
    int n = 0;
    while (!(eng_req && eng_phase == ph) && n < 5000) begin
      @(negedge clk); n++;
    end
  endtask

  // seq holds one nibble {phase, sector} per engine completion, lowest first
  task automatic chk_seq(input string r, input int n, input logic [31:0] seq);
    chk(r, "engine completions", 32'(log_n), 32'(n));
    for (int i = 0; i < n && i < log_n; i++)
      chk(r, "completion entry", 32'({log_p[i], log_s[i]}), 32'(seq[4*i +: 4]));
  endtask

  task automatic t_reset();
    chk("R1", "sel_mask", 32'(sel_mask), 32'd0);
    chk("R1", "win/busy/susp", 32'({win_open, busy, suspended}), 32'd0);
    chk("R1", "req/abort/prog_ok", 32'({eng_req, eng_abort, prog_ok}), 32'd0);
  endtask

  task automatic t_window_order();
    log_n = 0;
    pulse(C_SER, 3'd5);
    chk("R2", "window opens", 32'(win_open), 32'd1);
    repeat (9) @(negedge clk);
    pulse(C_SER, 3'd2);
    chk("R2", "sel after two", 32'(sel_mask), 32'h24);
    repeat (WIN_CYC - 1) @(negedge clk);
    chk("R2", "window still open", 32'(win_open), 32'd1);
    @(negedge clk);
    chk("R2", "window closed, busy", 32'({win_open, busy}), 32'b01);
    wait_idle("R4");
    chk_seq("R4", 4, 32'h0000_D5A2);
    chk("R4", "sel cleared", 32'(sel_mask), 32'd0);
  endtask

  task automatic t_cancel();
    log_n = 0;
    pulse(C_SER, 3'd3);
    pulse(C_OTH, 3'd0);
    chk("R3", "mode after cancel", 32'({win_open, busy, suspended}), 32'd0);
    chk("R3", "sel after cancel", 32'(sel_mask), 32'd0);
    repeat (WIN_CYC + 10) @(negedge clk);
    chk("R3", "no engine work", 32'(log_n), 32'd0);
  endtask

  task automatic t_protect_skip();
    log_n = 0;
    prot_mask = 8'b0000_1010;
    pulse(C_SER, 3'd1);
    pulse(C_SER, 3'd3);
    pulse(C_SER, 3'd7);
    pulse(C_SER, 3'd0);
    wait_idle("R5");
    chk_seq("R5", 4, 32'h0000_F780);
    prot_mask = '0;
  endtask

  task automatic t_all_protected();
    int n = 0;
    log_n = 0;
    prot_mask = 8'b1000_0000;
    pulse(C_SER, 3'd7);
    while (win_open) @(negedge clk);
    while (busy && n < 1000) begin
      if (eng_req) log_n = 99;
      @(negedge clk); n++;
    end
    chk("R6", "busy cycles", 32'(n), 32'(PROT_CYC + 1));
    chk("R6", "no engine request", 32'(log_n), 32'd0);
    chk("R6", "sel cleared", 32'(sel_mask), 32'd0);
    prot_mask = '0;
  endtask

  task automatic t_susp_window();
    log_n = 0;
    pulse(C_SUS, 3'd0);
    chk("R9", "suspend in read mode", 32'({suspended, busy}), 32'd0);
    pulse(C_SER, 3'd2);
    pulse(C_SUS, 3'd0);
    chk("R7", "susp/win/busy", 32'({suspended, win_open, busy}), 32'b100);
    chk("R7", "sel kept", 32'(sel_mask), 32'h04);
    repeat (WIN_CYC + 5) @(negedge clk);
    chk("R7", "still suspended", 32'(suspended), 32'd1);
    pulse(C_RES, 3'd0);
    chk("R11", "busy after resume", 32'({busy, suspended}), 32'b10);
    wait_idle("R11");
    chk_seq("R7", 2, 32'h0000_00A2);
  endtask

  task automatic t_susp_active();
    int k = 0;
    log_n = 0;
    ack_abort = 1'b0;
    pulse(C_SER, 3'd3);
    wait_phase(1'b1);
    pulse(C_SUS, 3'd0);
    chk("R8", "abort raised", 32'(eng_abort), 32'd1);
    while (!suspended && k < 100) begin @(negedge clk); k++; end
    chk("R8", "latency without ack", 32'(k), 32'(SUSP_LAT));
    pulse(C_RES, 3'd0);
    wait_idle("R8");
  endtask

  task automatic t_resume();
    int k = 0;
    ack_abort = 1'b1;
    pulse(C_SER, 3'd4);
    pulse(C_SER, 3'd6);
    wait_phase(1'b1);
    pulse(C_SUS, 3'd0);
    while (!suspended && k < 100) begin @(negedge clk); k++; end
    chk("R8", "ack ends drain early", 32'(k < SUSP_LAT), 32'd1);
    pulse(C_PRG, 3'd1);
    chk("R10", "prog to free sector", 32'(prog_ok), 32'd1);
    @(negedge clk);
    chk("R10", "prog_ok one cycle", 32'(prog_ok), 32'd0);
    pulse(C_PRG, 3'd6);
    chk("R10", "prog to selected sector", 32'(prog_ok), 32'd0);
    pulse(C_RES, 3'd0);
    chk("R11", "resumed", 32'({busy, suspended}), 32'b10);
    pulse(C_RES, 3'd0);
    chk("R11", "second resume ignored", 32'({busy, suspended}), 32'b10);
    wait_phase(1'b0);
    pulse(C_SUS, 3'd0);
    k = 0;
    while (!suspended && k < 100) begin @(negedge clk); k++; end
    chk("R11", "new suspend accepted", 32'(suspended), 32'd1);
    log_n = 0;
    pulse(C_RES, 3'd0);
    wait_idle("R11");
    chk_seq("R11", 4, 32'h0000_E6C4);
    ack_abort = 1'b0;
  endtask

  task automatic t_ignore_busy();
    log_n = 0;
    pulse(C_SER, 3'd0);
    wait_phase(1'b0);
    pulse(C_OTH, 3'd0);
    pulse(C_SER, 3'd6);
    pulse(C_RES, 3'd0);
    pulse(C_PRG, 3'd3);
    chk("R12", "no prog_ok while busy", 32'(prog_ok), 32'd0);
    chk("R12", "sel unchanged", 32'(sel_mask), 32'h01);
    chk("R12", "still busy", 32'(busy), 32'd1);
    wait_idle("R12");
    chk_seq("R12", 2, 32'h0000_0080);
    pulse(C_PRG, 3'd3);
    chk("R10", "prog in read mode", 32'(prog_ok), 32'd1);
  endtask

  task automatic t_chip();
    int bad = 0;
    log_n = 0;
    pulse(C_CER, 3'd0);
    chk("R9", "chip erase busy/sel", 32'({busy, sel_mask}), 32'h1FF);
    wait_phase(1'b0);
    pulse(C_SUS, 3'd0);
    chk("R9", "suspend ignored in chip erase", 32'({suspended, eng_abort, busy}), 32'b001);
    wait_idle("R9");
    chk("R4", "chip completions", 32'(log_n), 32'd16);
    for (int i = 0; i < 16 && i < log_n; i++)
      if (log_s[i] != 3'(i / 2) || log_p[i] != 1'(i % 2)) bad++;
    chk("R4", "chip order mismatches", 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window_order();
    t_cancel();
    t_protect_skip();
    t_all_protected();
    t_susp_window();
    t_susp_active();
    t_resume();
    t_ignore_busy();
    t_chip();
    summary_exit();
  end
endmodule